// File: doc/BRIEF.md
# Asynchronous Timer Register Write Bridge

This block carries register writes from a fast I/O-clock bus into a timer that runs on a slow, unrelated clock, such as a 32.768 kHz oscillator. Three timer registers are served: the counter, the compare value and the control byte. Each has its own write channel. A channel has a holding register and an update-busy flag. The flag rises on a bus write. It stays up until the held value has been committed on the timer side and the acknowledgement has travelled back. Each channel is independent, so a write to one register never disturbs a transfer that is still in flight on another.

Data crosses through a toggle handshake. The bus write flips a request bit, which the timer domain samples on one edge and acts on at the next. The held value therefore reaches its timer register on exactly the second rising timer edge after the write. The acknowledgement is a copy of the request bit. It goes back through two I/O flops and clears the busy flag. Compare and control reads return the holding register. Counter reads return a snapshot of the live count. The snapshot is taken in the I/O domain shortly after each rising timer edge, which requires the I/O clock to be more than four times faster than the timer clock. For test purposes the timer is a plain counter. It counts when control bit 0 is set, and it drives a compare-match output. That output is held low while a compare or counter transfer is pending in the timer domain.

Each channel is a two-state machine, CH_IDLE and CH_BUSY:
- GO moves it from CH_IDLE to CH_BUSY on a write and flips the request.
- DONE returns it to CH_IDLE once the acknowledgement matches the request.
- RELAUNCH keeps it in CH_BUSY when a write arrives in the cycle the acknowledgement lands, and starts a fresh transfer.
- A write in CH_BUSY before DONE overwrites the held value and sets a sticky error.

The counter snapshot logic is a second two-state machine, SV_WAIT_LOW and SV_WAIT_HIGH:
- ARM moves it from SV_WAIT_LOW to SV_WAIT_HIGH when the synchronised timer clock is seen low.
- CAPTURE moves it back to SV_WAIT_LOW when that clock is seen high, and copies the count at the same time.

Top module: `async_timer_bridge`

## Requirements
- R1: After reset every readable location returns 0, all timer registers are 0, the error flag is 0, and the compare-match output is 1 because count and compare are both 0.
- R2: A write to address 0 (counter), 1 (compare) or 2 (control) sets that register's busy bit in the status byte at address 3 from the next I/O cycle. The busy bits are counter in bit 2, compare in bit 1 and control in bit 0. Reading address 1 or 2 returns the last value written at once.
- R3: A written value appears on the timer-side register on the second rising timer edge after the write, and not on the first.
- R4: A busy bit stays set across the first timer edge after its write. It clears within a few I/O cycles after the commit edge, once the acknowledgement has passed two I/O flops.
- R5: Transfers are independent. A control write issued while a compare transfer is pending commits on its own second edge and leaves the compare transfer untouched.
- R6: Reading address 0 returns the timer count as copied after the most recent rising timer edge. Just after a timer edge the read still shows the previous value. The count increments on each timer edge when committed control bit 0 is 1, and it holds when that bit is 0. A committed counter write takes priority over the increment.
- R7: In the status byte, bit 3 is a read/write clock-source select, driven out on `src_sel`. Bits 7 to 4 read as 0. Writes to the status byte do not change the busy bits.
- R8: `cmp_match` is 1 when the timer count equals the committed compare value. It is forced to 0 from the first timer edge after a compare or counter write until that write commits.
- R9: A write to a register whose transfer is still busy is accepted, and the last value wins. It sets the sticky `wr_err` output, which only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | Fast bus clock |
| clk_tmr | input | 1 | Slow asynchronous timer clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one I/O cycle per write |
| bus_addr | input | 2 | Register select: 0 counter, 1 compare, 2 control, 3 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected address |
| src_sel | output | 1 | Clock-source select bit from the status byte |
| wr_err | output | 1 | Sticky flag set when a write is made while that register is busy |
| tmr_cnt | output | DATA_W | Timer-domain counter value |
| tmr_cmp | output | DATA_W | Timer-domain committed compare value |
| tmr_ctl | output | DATA_W | Timer-domain committed control value |
| cmp_match | output | 1 | Count equals compare, suppressed while a compare or counter transfer is pending |

## Verification
The bench counts timer edges after each write. A bridge that committed on the first edge, or on the third, shows a wrong timer-side value at one of the two sampled edges. A bridge that cleared the busy flag too early shows it clear right after the first edge. The bench also fires a compare write and a control write one timer edge apart, and writes the same register twice back to back. A shared handshake would delay or lose one of the two transfers. Missing error tracking leaves `wr_err` low, or lets the first value win. The counter read is sampled just after a timer edge, where a live, unsynchronised read path would already show the new count. A counter write lands while the count is running, where a bridge that gave the increment priority over the load would be off by one. Rewriting the compare value while count and compare are equal checks that `cmp_match` drops for exactly the pending window.

// File: rtl/atb_pkg.sv
package atb_pkg;

    // Register address width and the address of each location.
    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] A_CNT  = 2'd0;
    localparam logic [REG_AW-1:0] A_CMP  = 2'd1;
    localparam logic [REG_AW-1:0] A_CTL  = 2'd2;
    localparam logic [REG_AW-1:0] A_STAT = 2'd3;

    // Channel numbering inside the bridge.
    localparam int NCHAN  = 3;
    localparam int CH_CNT = 0;
    localparam int CH_CMP = 1;
    localparam int CH_CTL = 2;

    // Status byte bit positions.
    localparam int ST_BUSY_CTL = 0;
    localparam int ST_BUSY_CMP = 1;
    localparam int ST_BUSY_CNT = 2;
    localparam int ST_SRC      = 3;

    // Control bit that lets the test counter run.
    localparam int RUN_BIT = 0;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;

    typedef enum logic {
        SV_WAIT_LOW  = 1'b0,
        SV_WAIT_HIGH = 1'b1
    } view_state_e;

endpackage

// File: rtl/atb_wr_chan.sv
module atb_wr_chan
    import atb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk_io,
    input  logic          clk_tmr,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          err_q,
    output logic [DW-1:0] hold_q,
    output logic          t_load,
    output logic [DW-1:0] t_data
);

    ch_state_e st_q, st_d;
    logic      req_q;
    logic      ack_s1, ack_s2;
    logic      req_s1, ack_t;
    logic      done;
    logic      launch;

    // Acknowledge matches request once the timer side has committed.
    assign done = (ack_s2 == req_q);

    // Next-state logic: GO, DONE and RELAUNCH transitions.
    always_comb begin
        st_d   = st_q;
        launch = 1'b0;
        unique case (st_q)
            CH_IDLE: begin
                if (wr_en) begin
                    st_d   = CH_BUSY;
                    launch = 1'b1;
                end
            end
            CH_BUSY: begin
                if (done) begin
                    if (wr_en) begin
                        st_d   = CH_BUSY;
                        launch = 1'b1;
                    end else begin
                        st_d = CH_IDLE;
                    end
                end
            end
            default: st_d = CH_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_io or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // I/O-domain outputs: holding register, request toggle, error, ack sync.
    always_ff @(posedge clk_io or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            req_q  <= 1'b0;
            err_q  <= 1'b0;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_q <= wr_data;
            end
            if (launch) begin
                req_q <= ~req_q;
            end
            if (wr_en && (st_q == CH_BUSY) && !done) begin
                err_q <= 1'b1;
            end
            ack_s1 <= ack_t;
            ack_s2 <= ack_s1;
        end
    end

    assign busy = (st_q == CH_BUSY);

    // Timer domain: first edge samples the request, second edge commits.
    always_ff @(posedge clk_tmr or negedge rst_n) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            ack_t  <= 1'b0;
        end else begin
            req_s1 <= req_q;
            ack_t  <= req_s1;
        end
    end

    assign t_load = (req_s1 != ack_t);
    assign t_data = hold_q;

    AST_BUSY_AFTER_GO: assert property (@(posedge clk_io) disable iff (!rst_n)
        (wr_en && (st_q == CH_IDLE)) |=> busy); // R2

    AST_BUSY_CLEARS_ON_ACK: assert property (@(posedge clk_io) disable iff (!rst_n)
        $fell(busy) |-> (ack_s2 == req_q)); // R4

    AST_HOLD_STEADY: assert property (@(posedge clk_io) disable iff (!rst_n)
        (busy && !wr_en) |=> $stable(hold_q)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk_io) disable iff (!rst_n)
        err_q |=> err_q); // R9

endmodule

// File: rtl/atb_cnt_view.sv
module atb_cnt_view
    import atb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk_io,
    input  logic          rst_n,
    input  logic          clk_tmr,
    input  logic [DW-1:0] cnt_t,
    output logic [DW-1:0] cnt_rd
);

    view_state_e st_q, st_d;
    logic        tk_s1, tk_s2;
    logic        capture;

    // Two-flop sampling of the timer clock level.
    always_ff @(posedge clk_io or negedge rst_n) begin
        if (!rst_n) begin
            tk_s1 <= 1'b0;
            tk_s2 <= 1'b0;
        end else begin
            tk_s1 <= clk_tmr;
            tk_s2 <= tk_s1;
        end
    end

    // ARM and CAPTURE transitions.
    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        unique case (st_q)
            SV_WAIT_LOW: begin
                if (!tk_s2) begin
                    st_d = SV_WAIT_HIGH;
                end
            end
            SV_WAIT_HIGH: begin
                if (tk_s2) begin
                    st_d    = SV_WAIT_LOW;
                    capture = 1'b1;
                end
            end
            default: st_d = SV_WAIT_LOW;
        endcase
    end

    always_ff @(posedge clk_io or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SV_WAIT_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_io or negedge rst_n) begin
        if (!rst_n) begin
            cnt_rd <= '0;
        end else if (capture) begin
            cnt_rd <= cnt_t;
        end
    end

    AST_VIEW_HOLDS: assert property (@(posedge clk_io) disable iff (!rst_n)
        (st_q == SV_WAIT_LOW) |=> $stable(cnt_rd)); // R6

endmodule

// File: rtl/atb_tmr_core.sv
module atb_tmr_core
    import atb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk_tmr,
    input  logic          rst_n,
    input  logic          ld_cnt,
    input  logic          ld_cmp,
    input  logic          ld_ctl,
    input  logic [DW-1:0] cnt_in,
    input  logic [DW-1:0] cmp_in,
    input  logic [DW-1:0] ctl_in,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] cmp_q,
    output logic [DW-1:0] ctl_q,
    output logic          cmp_match
);

    always_ff @(posedge clk_tmr or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
            ctl_q <= '0;
        end else begin
            if (ld_cnt) begin
                cnt_q <= cnt_in;
            end else if (ctl_q[RUN_BIT]) begin
                cnt_q <= cnt_q + DW'(1);
            end
            if (ld_cmp) begin
                cmp_q <= cmp_in;
            end
            if (ld_ctl) begin
                ctl_q <= ctl_in;
            end
        end
    end

    assign cmp_match = (cnt_q == cmp_q) && !ld_cnt && !ld_cmp;

    AST_CMP_HOLD: assert property (@(posedge clk_tmr) disable iff (!rst_n)
        !ld_cmp |=> $stable(cmp_q)); // R3

    AST_CTL_HOLD: assert property (@(posedge clk_tmr) disable iff (!rst_n)
        !ld_ctl |=> $stable(ctl_q)); // R5

    AST_CNT_STEP: assert property (@(posedge clk_tmr) disable iff (!rst_n)
        (!ld_cnt && ctl_q[RUN_BIT]) |=> (cnt_q == $past(cnt_q) + DW'(1))); // R6

    AST_CNT_FROZEN: assert property (@(posedge clk_tmr) disable iff (!rst_n)
        (!ld_cnt && !ctl_q[RUN_BIT]) |=> $stable(cnt_q)); // R6

    AST_NO_MATCH_PENDING: assert property (@(posedge clk_tmr) disable iff (!rst_n)
        (ld_cnt || ld_cmp) |-> !cmp_match); // R8

endmodule

// File: rtl/async_timer_bridge.sv
module async_timer_bridge
    import atb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_io,
    input  logic              clk_tmr,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              src_sel,
    output logic              wr_err,
    output logic [DATA_W-1:0] tmr_cnt,
    output logic [DATA_W-1:0] tmr_cmp,
    output logic [DATA_W-1:0] tmr_ctl,
    output logic              cmp_match
);

    logic [NCHAN-1:0]  ch_wr;
    logic [NCHAN-1:0]  ch_busy;
    logic [NCHAN-1:0]  ch_err;
    logic [NCHAN-1:0]  ch_load;
    logic [DATA_W-1:0] ch_hold [NCHAN];
    logic [DATA_W-1:0] ch_tdat [NCHAN];
    logic [DATA_W-1:0] cnt_rd;
    logic              src_q;

    // One write channel per timer register; channel index equals address.
    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        assign ch_wr[g] = bus_wr && (bus_addr == REG_AW'(g));

        atb_wr_chan #(.DW(DATA_W)) chan_i (
            .clk_io  (clk_io),
            .clk_tmr (clk_tmr),
            .rst_n   (rst_n),
            .wr_en   (ch_wr[g]),
            .wr_data (bus_wdata),
            .busy    (ch_busy[g]),
            .err_q   (ch_err[g]),
            .hold_q  (ch_hold[g]),
            .t_load  (ch_load[g]),
            .t_data  (ch_tdat[g])
        );
    end

    atb_tmr_core #(.DW(DATA_W)) core_i (
        .clk_tmr   (clk_tmr),
        .rst_n     (rst_n),
        .ld_cnt    (ch_load[CH_CNT]),
        .ld_cmp    (ch_load[CH_CMP]),
        .ld_ctl    (ch_load[CH_CTL]),
        .cnt_in    (ch_tdat[CH_CNT]),
        .cmp_in    (ch_tdat[CH_CMP]),
        .ctl_in    (ch_tdat[CH_CTL]),
        .cnt_q     (tmr_cnt),
        .cmp_q     (tmr_cmp),
        .ctl_q     (tmr_ctl),
        .cmp_match (cmp_match)
    );

    atb_cnt_view #(.DW(DATA_W)) view_i (
        .clk_io  (clk_io),
        .rst_n   (rst_n),
        .clk_tmr (clk_tmr),
        .cnt_t   (tmr_cnt),
        .cnt_rd  (cnt_rd)
    );

    // Clock-source select lives in the I/O domain.
    always_ff @(posedge clk_io or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= 1'b0;
        end else if (bus_wr && (bus_addr == A_STAT)) begin
            src_q <= bus_wdata[ST_SRC];
        end
    end

    assign src_sel = src_q;
    assign wr_err  = |ch_err;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CNT:  bus_rdata = cnt_rd;
            A_CMP:  bus_rdata = ch_hold[CH_CMP];
            A_CTL:  bus_rdata = ch_hold[CH_CTL];
            A_STAT: begin
                bus_rdata[ST_SRC]      = src_q;
                bus_rdata[ST_BUSY_CNT] = ch_busy[CH_CNT];
                bus_rdata[ST_BUSY_CMP] = ch_busy[CH_CMP];
                bus_rdata[ST_BUSY_CTL] = ch_busy[CH_CTL];
            end
            default: bus_rdata = '0;
        endcase
    end

    AST_STAT_UPPER_ZERO: assert property (@(posedge clk_io) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> (bus_rdata[DATA_W-1:4] == '0)); // R7

    AST_SRC_FOLLOWS_WRITE: assert property (@(posedge clk_io) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_STAT)) |=> (src_sel == $past(bus_wdata[ST_SRC]))); // R7

endmodule

// File: tb/async_timer_bridge_tb.sv
module async_timer_bridge_tb_top;
    import atb_pkg::*;

    logic       clk_io  = 1'b0;
    logic       clk_tmr = 1'b0;
    logic       rst_n   = 1'b0;
    logic       bus_wr  = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       src_sel, wr_err, cmp_match;
    logic [7:0] tmr_cnt, tmr_cmp, tmr_ctl;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] sb_exp[$];
    string      sb_tag[$];
    logic [7:0] mon_e;
    string      mon_t;

    always #2 clk_io = ~clk_io;     // 250 MHz
    always #40 clk_tmr = ~clk_tmr;  // 20x slower timer clock

    async_timer_bridge #(.DATA_W(8)) dut_i (
        .clk_io    (clk_io),
        .clk_tmr   (clk_tmr),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_sel   (src_sel),
        .wr_err    (wr_err),
        .tmr_cnt   (tmr_cnt),
        .tmr_cmp   (tmr_cmp),
        .tmr_ctl   (tmr_ctl),
        .cmp_match (cmp_match)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    // Scoreboard monitor: compares read data against queued expectations.
    always @(negedge clk_io) begin
        if (sb_exp.size() != 0) begin
            mon_e = sb_exp.pop_front();
            mon_t = sb_tag.pop_front();
            chk(bus_rdata, mon_e, mon_t);
        end
    end

    task automatic wio(input int n);
        repeat (n) @(posedge clk_io);
        #1;
    endtask

    task automatic tedge();
        @(posedge clk_tmr);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk_io);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_io);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(posedge clk_io);
        #1;
        bus_addr = a;
        sb_exp.push_back(e);
        sb_tag.push_back(tag);
        wait (sb_exp.size() == 0);
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        wio(10);
        @(negedge clk_io);
        rst_n = 1'b1;
        wio(2);

        // R1 reset state
        rd_chk(A_CNT, 8'h00, "R1 cnt read");
        rd_chk(A_CMP, 8'h00, "R1 cmp read");
        rd_chk(A_CTL, 8'h00, "R1 ctl read");
        rd_chk(A_STAT, 8'h00, "R1 status read");
        chk({7'd0, wr_err}, 8'h00, "R1 wr_err");
        chk(tmr_cmp, 8'h00, "R1 tmr_cmp");
        chk({7'd0, cmp_match}, 8'h01, "R1 cmp_match");

        // R2 / R3 / R4 single compare write
        tedge();
        wr(A_CMP, 8'h5A);
        rd_chk(A_STAT, 8'h02, "R2 cmp busy bit");
        rd_chk(A_CMP, 8'h5A, "R2 cmp temp read");
        tedge();
        chk(tmr_cmp, 8'h00, "R3 not yet after first edge");
        wio(6);
        rd_chk(A_STAT, 8'h02, "R4 busy after first edge");
        tedge();
        chk(tmr_cmp, 8'h5A, "R3 committed on second edge");
        wio(6);
        rd_chk(A_STAT, 8'h00, "R4 busy cleared");

        // R5 independent channels
        tedge();
        wr(A_CMP, 8'hA5);
        tedge();
        wr(A_CTL, 8'h3C);
        tedge();
        chk(tmr_cmp, 8'hA5, "R5 cmp commit");
        chk(tmr_ctl, 8'h00, "R5 ctl still pending");
        wio(6);
        rd_chk(A_STAT, 8'h01, "R5 only ctl busy");
        tedge();
        chk(tmr_ctl, 8'h3C, "R5 ctl commit");
        chk(tmr_cmp, 8'hA5, "R5 cmp undisturbed");
        wio(6);
        rd_chk(A_STAT, 8'h00, "R5 all idle");
        rd_chk(A_CTL, 8'h3C, "R5 ctl read");

        // R9 write while busy
        tedge();
        wr(A_CMP, 8'h11);
        wr(A_CMP, 8'h22);
        chk({7'd0, wr_err}, 8'h01, "R9 error set");
        rd_chk(A_CMP, 8'h22, "R9 last value read");
        tedge();
        tedge();
        chk(tmr_cmp, 8'h22, "R9 last value committed");
        wio(6);
        rd_chk(A_STAT, 8'h00, "R9 busy cleared");
        chk({7'd0, wr_err}, 8'h01, "R9 error sticky");

        // R7 status byte
        wr(A_STAT, 8'hFF);
        chk({7'd0, src_sel}, 8'h01, "R7 src_sel set");
        rd_chk(A_STAT, 8'h08, "R7 status upper zero");
        wr(A_STAT, 8'h00);
        chk({7'd0, src_sel}, 8'h00, "R7 src_sel clear");
        rd_chk(A_STAT, 8'h00, "R7 status clear");

        // R8 match suppression
        tedge();
        wr(A_CNT, 8'h22);
        tedge();
        tedge();
        chk({7'd0, cmp_match}, 8'h01, "R8 match when equal");
        wr(A_CMP, 8'h22);
        tedge();
        chk({7'd0, cmp_match}, 8'h00, "R8 suppressed while pending");
        tedge();
        chk({7'd0, cmp_match}, 8'h01, "R8 match after commit");

        // R6 counter read path
        wr(A_CNT, 8'h40);
        tedge();
        tedge();
        wio(6);
        rd_chk(A_CNT, 8'h40, "R6 counter read after load");
        wr(A_CTL, 8'h01);
        tedge();
        chk(tmr_cnt, 8'h40, "R6 frozen while stopped");
        tedge();
        chk(tmr_cnt, 8'h40, "R6 run commit edge no step");
        wio(6);
        rd_chk(A_CNT, 8'h40, "R6 read before step");
        tedge();
        chk(tmr_cnt, 8'h41, "R6 counter stepped");
        chk(bus_rdata, 8'h40, "R6 read holds previous just after edge");
        wio(6);
        rd_chk(A_CNT, 8'h41, "R6 read refreshed");
        wr(A_CNT, 8'h90);
        tedge();
        chk(tmr_cnt, 8'h42, "R6 runs while load pending");
        tedge();
        chk(tmr_cnt, 8'h90, "R6 load wins over step");
        tedge();
        chk(tmr_cnt, 8'h91, "R6 runs after load");
        wr(A_CTL, 8'h00);
        wio(4);

        finish_up();
    end

endmodule